// File: doc/BRIEF.md
# Qualified Fixed-Frequency Clock Generator

The block turns one of two slow reference clocks into a low, fixed-frequency clock for peripherals. A select input picks the slow internal reference or the external reference. The chosen reference is divided by a power-of-two ratio taken from a register input. The references are sampled into the main output clock domain, which is faster, and the divider advances on the sampled edges. The divided clock is then synchronized into the peripheral bus clock domain, where the output register is updated only on bus clock edges.

The output counts as usable only while its period is at least `MIN_RATIO` main clock cycles. Each divided period is measured against that limit. While the output is not usable, it is held high. It is also held high in the bypassed low-power internal mode and in stop mode. Changing the source, the divider code or the range setting restarts the divider and drops validity, so the output stays high until a full new period has been measured. Because the references are sampled, each reference high and low phase must last at least two main clock cycles.

Top module: `ffclk_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until a divided period has been qualified, `ffclk_out` is 1.
- R2: `src_sel_ext` = 0 selects `int_ref_clk` as the source and `src_sel_ext` = 1 selects `ext_ref_clk`.
- R3: With the internal source, a `div_sel` value k gives an output period of 2^k source periods. The duty cycle is exactly 50 % for k >= 1 (k = 0 up to 7 with the default `DIV_SEL_W` = 3).
- R4: With the external source and `ext_range_hi` = 1, the ratio is 2^(k + `EXT_SHIFT`). With the internal source, `ext_range_hi` has no effect on the period.
- R5: A divided period shorter than `MIN_RATIO` main clock cycles keeps `ffclk_out` at 1. A period of exactly `MIN_RATIO` cycles or more lets it toggle. The test is made on the divided clock, not on the raw source.
- R6: Validity is re-evaluated at every rising edge of the divided clock. If the source speeds up during operation so that the period falls below the limit, `ffclk_out` returns to constant 1.
- R7: Any change of `src_sel_ext`, `ext_range_hi` or `div_sel` clears validity on the next main clock edge and restarts the divider. `ffclk_out` stays 1 until two new divided rising edges have been seen, and then toggles at the new period.
- R8: While `stop_mode` is 1, `ffclk_out` is 1 from the next bus clock edge on. After `stop_mode` is released, toggling resumes without requalification.
- R9: While `blpi_mode` is 1, `ffclk_out` is 1 from the next bus clock edge on. Toggling resumes after release.
- R10: `ffclk_out` changes only on `bus_clk` edges. It falls only one edge after a synchronized falling edge of the divided clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| main_clk | input | 1 | Main output clock; samples the references and runs divider and ratio check |
| bus_clk | input | 1 | Peripheral bus clock; clocks the output register |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| int_ref_clk | input | 1 | Slow internal reference clock |
| ext_ref_clk | input | 1 | External reference clock |
| src_sel_ext | input | 1 | 0: internal reference, 1: external reference |
| div_sel | input | DIV_SEL_W | Divider code k, ratio 2^k |
| ext_range_hi | input | 1 | Adds EXT_SHIFT to k when the external source is selected |
| blpi_mode | input | 1 | Bypassed low-power internal mode; forces the output high |
| stop_mode | input | 1 | Stop mode; forces the output high |
| ffclk_out | output | 1 | Qualified fixed-frequency clock, high when not valid |

## Verification
The bench builds the block with `DIV_SEL_W` = 3, `EXT_SHIFT` = 2 and `MIN_RATIO` = 8, and it feeds one 125 MHz clock to both `main_clk` and `bus_clk`. Every divided period is therefore an exact whole number of cycles. With a minimum ratio of 8, the boundary between a 7-cycle period, which is held high, and an 8-cycle period, which toggles, can be reached with reference phases only a few cycles long. The same goes for a fast source that becomes usable after division by two. A 3-bit code still reaches the top ratio of 128 within a few thousand cycles, and the shift of 2 makes the external range extension visible as a factor of four.

// File: rtl/ffclk_pkg.sv
package ffclk_pkg;

  // Qualification state of the divided clock
  typedef enum logic [1:0] {
    QS_IDLE  = 2'd0,  // no divided edge seen since restart
    QS_ARMED = 2'd1,  // one edge seen, period being measured
    QS_VALID = 2'd2   // last measured period met the limit
  } qual_state_e;

  // Effective log2 of the divide ratio
  function automatic int eff_div_log(input int code, input bit use_ext,
                                     input bit range_hi, input int ext_shift);
    return code + ((use_ext && range_hi) ? ext_shift : 0);
  endfunction

  // cycles_since_edge equals (period - 1) at the closing rising edge
  function automatic bit period_meets(input int cycles_since_edge, input int min_ratio);
    return cycles_since_edge >= (min_ratio - 1);
  endfunction

endpackage

// File: rtl/ffclk_sync.sv
module ffclk_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= {STAGES{RST_VAL}};
    else        shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/ffclk_divider.sv
module ffclk_divider #(
  parameter int DIV_SEL_W   = 3,
  parameter int EXT_SHIFT   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 main_clk,
  input  logic                 rst_n,
  input  logic                 int_ref_clk,
  input  logic                 ext_ref_clk,
  input  logic                 src_sel_ext,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic                 ext_range_hi,
  output logic                 dclk,
  output logic                 dclk_rise,
  output logic                 cfg_chg
);
  localparam int LOG_MAX = (1 << DIV_SEL_W) - 1 + EXT_SHIFT;
  localparam int CNT_W   = LOG_MAX + 1;
  localparam int IDX_W   = $clog2(CNT_W);
  localparam int CFG_W   = DIV_SEL_W + 2;

  // sample both references into the main clock domain
  logic [1:0] ref_raw, ref_smp;
  assign ref_raw = {ext_ref_clk, int_ref_clk};

  for (genvar g = 0; g < 2; g++) begin : g_ref_sync
    ffclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk  (main_clk),
      .rst_n(rst_n),
      .d    (ref_raw[g]),
      .q    (ref_smp[g])
    );
  end

  // configuration change detection
  logic [CFG_W-1:0] cfg_now, cfg_q;
  assign cfg_now = {src_sel_ext, ext_range_hi, div_sel};
  assign cfg_chg = (cfg_now != cfg_q);

  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;
  end

  // source edge detection (both edges advance the half-period counter)
  logic src_lvl, src_prev, src_edge;
  assign src_lvl  = src_sel_ext ? ref_smp[1] : ref_smp[0];
  assign src_edge = src_lvl ^ src_prev;

  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) src_prev <= 1'b0;
    else        src_prev <= src_lvl;
  end

  // bit k of the half-period counter has a period of 2^k source periods
  logic [CNT_W-1:0] half_cnt;
  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n)        half_cnt <= '0;
    else if (cfg_chg)  half_cnt <= '0;
    else if (src_edge) half_cnt <= half_cnt + 1'b1;
  end

  logic [IDX_W-1:0] eff_idx;
  always_comb begin
    eff_idx = IDX_W'(ffclk_pkg::eff_div_log(int'(div_sel), src_sel_ext,
                                            ext_range_hi, EXT_SHIFT));
  end

  logic dclk_q, dclk_prev;
  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q    <= 1'b0;
      dclk_prev <= 1'b0;
    end else begin
      dclk_q    <= cfg_chg ? 1'b0 : half_cnt[eff_idx];
      dclk_prev <= dclk_q;
    end
  end

  assign dclk      = dclk_q;
  assign dclk_rise = dclk_q & ~dclk_prev;
endmodule

// File: rtl/ffclk_ratio_qual.sv
module ffclk_ratio_qual #(
  parameter int MIN_RATIO = 8
) (
  input  logic main_clk,
  input  logic rst_n,
  input  logic dclk_rise,
  input  logic cfg_chg,
  output logic valid,
  output logic period_ok
);
  import ffclk_pkg::*;

  localparam int PCNT_W = (MIN_RATIO > 2) ? $clog2(MIN_RATIO) : 1;
  localparam logic [PCNT_W-1:0] SAT = PCNT_W'(MIN_RATIO - 1);

  logic [PCNT_W-1:0] since_edge;
  qual_state_e       state_q, state_d;

  assign period_ok = period_meets(int'(since_edge), MIN_RATIO);

  // saturating count of main cycles since the last divided rising edge
  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n)                     since_edge <= '0;
    else if (cfg_chg || dclk_rise)  since_edge <= '0;
    else if (since_edge != SAT)     since_edge <= since_edge + 1'b1;
  end

  always_comb begin
    state_d = state_q;
    if (cfg_chg) begin
      state_d = QS_IDLE;
    end else if (dclk_rise) begin
      case (state_q)
        QS_IDLE: state_d = QS_ARMED;
        default: state_d = period_ok ? QS_VALID : QS_ARMED;
      endcase
    end
  end

  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) state_q <= QS_IDLE;
    else        state_q <= state_d;
  end

  assign valid = (state_q == QS_VALID);
endmodule

// File: rtl/ffclk_bus_out.sv
module ffclk_bus_out #(
  parameter int SYNC_STAGES = 2
) (
  input  logic bus_clk,
  input  logic rst_n,
  input  logic dclk_m,
  input  logic valid_m,
  input  logic blpi_mode,
  input  logic stop_mode,
  output logic valid_b,
  output logic gate,
  output logic b_rise,
  output logic b_fall,
  output logic ffclk_out
);
  logic [1:0] xin, xout;
  assign xin = {valid_m, dclk_m};

  for (genvar g = 0; g < 2; g++) begin : g_bus_sync
    ffclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk  (bus_clk),
      .rst_n(rst_n),
      .d    (xin[g]),
      .q    (xout[g])
    );
  end

  logic dclk_b, dclk_b_q, out_q;
  assign dclk_b  = xout[0];
  assign valid_b = xout[1];
  assign gate    = blpi_mode | stop_mode;
  assign b_rise  = dclk_b & ~dclk_b_q;
  assign b_fall  = ~dclk_b & dclk_b_q;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_b_q <= 1'b0;
      out_q    <= 1'b1;
    end else begin
      dclk_b_q <= dclk_b;
      if (gate || !valid_b) out_q <= 1'b1;
      else if (b_rise)      out_q <= 1'b1;
      else if (b_fall)      out_q <= 1'b0;
    end
  end

  assign ffclk_out = out_q;
endmodule

// File: rtl/ffclk_gen.sv
module ffclk_gen #(
  parameter int DIV_SEL_W   = 3,
  parameter int EXT_SHIFT   = 2,
  parameter int MIN_RATIO   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 main_clk,
  input  logic                 bus_clk,
  input  logic                 rst_n,
  input  logic                 int_ref_clk,
  input  logic                 ext_ref_clk,
  input  logic                 src_sel_ext,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic                 ext_range_hi,
  input  logic                 blpi_mode,
  input  logic                 stop_mode,
  output logic                 ffclk_out
);
  // internal events brought out for the checker
  logic w_dclk, w_dclk_rise, w_cfg_chg;
  logic w_valid_m, w_period_ok;
  logic w_valid_b, w_gate, w_b_rise, w_b_fall;

  ffclk_divider #(
    .DIV_SEL_W  (DIV_SEL_W),
    .EXT_SHIFT  (EXT_SHIFT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_div (
    .main_clk    (main_clk),
    .rst_n       (rst_n),
    .int_ref_clk (int_ref_clk),
    .ext_ref_clk (ext_ref_clk),
    .src_sel_ext (src_sel_ext),
    .div_sel     (div_sel),
    .ext_range_hi(ext_range_hi),
    .dclk        (w_dclk),
    .dclk_rise   (w_dclk_rise),
    .cfg_chg     (w_cfg_chg)
  );

  ffclk_ratio_qual #(.MIN_RATIO(MIN_RATIO)) u_qual (
    .main_clk (main_clk),
    .rst_n    (rst_n),
    .dclk_rise(w_dclk_rise),
    .cfg_chg  (w_cfg_chg),
    .valid    (w_valid_m),
    .period_ok(w_period_ok)
  );

  ffclk_bus_out #(.SYNC_STAGES(SYNC_STAGES)) u_out (
    .bus_clk  (bus_clk),
    .rst_n    (rst_n),
    .dclk_m   (w_dclk),
    .valid_m  (w_valid_m),
    .blpi_mode(blpi_mode),
    .stop_mode(stop_mode),
    .valid_b  (w_valid_b),
    .gate     (w_gate),
    .b_rise   (w_b_rise),
    .b_fall   (w_b_fall),
    .ffclk_out(ffclk_out)
  );
endmodule

// File: rtl/ffclk_gen_chk.sv
module ffclk_gen_chk (
  input logic main_clk,
  input logic bus_clk,
  input logic rst_n,
  input logic cfg_chg,
  input logic dclk_rise,
  input logic valid_m,
  input logic valid_b,
  input logic b_fall,
  input logic blpi_mode,
  input logic stop_mode,
  input logic ffclk_out
);
  AST_INVALID_HIGH: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !valid_b |=> ffclk_out); // R5

  AST_VALID_ON_DIV_EDGE: assert property (@(posedge main_clk) disable iff (!rst_n)
    $rose(valid_m) |-> $past(dclk_rise)); // R6

  AST_CFG_DROPS_VALID: assert property (@(posedge main_clk) disable iff (!rst_n)
    cfg_chg |=> !valid_m); // R7

  AST_STOP_HIGH: assert property (@(posedge bus_clk) disable iff (!rst_n)
    stop_mode |=> ffclk_out); // R8

  AST_BLPI_HIGH: assert property (@(posedge bus_clk) disable iff (!rst_n)
    blpi_mode |=> ffclk_out); // R9

  AST_FALL_AFTER_SYNC_EDGE: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $fell(ffclk_out) |-> $past(b_fall)); // R10
endmodule

bind ffclk_gen ffclk_gen_chk u_chk (
  .main_clk (main_clk),
  .bus_clk  (bus_clk),
  .rst_n    (rst_n),
  .cfg_chg  (w_cfg_chg),
  .dclk_rise(w_dclk_rise),
  .valid_m  (w_valid_m),
  .valid_b  (w_valid_b),
  .b_fall   (w_b_fall),
  .blpi_mode(blpi_mode),
  .stop_mode(stop_mode),
  .ffclk_out(ffclk_out)
);

// File: tb/ffclk_gen_tb.sv
module ffclk_gen_tb;
  localparam int DIV_SEL_W = 3;
  localparam int EXT_SHIFT = 2;
  localparam int MIN_RATIO = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst_n = 1'b1;
  logic int_ref = 1'b0, ext_ref = 1'b0;
  logic sel_ext = 1'b0, rng_hi = 1'b0, blpi = 1'b0, stop = 1'b0;
  logic [DIV_SEL_W-1:0] div = '0;
  logic ffclk_out;

  int int_hi = 5, int_lo = 5, ext_hi = 7, ext_lo = 7;

  ffclk_gen #(.DIV_SEL_W(DIV_SEL_W), .EXT_SHIFT(EXT_SHIFT), .MIN_RATIO(MIN_RATIO)) u_dut (
    .main_clk    (clk),
    .bus_clk     (clk),
    .rst_n       (rst_n),
    .int_ref_clk (int_ref),
    .ext_ref_clk (ext_ref),
    .src_sel_ext (sel_ext),
    .div_sel     (div),
    .ext_range_hi(rng_hi),
    .blpi_mode   (blpi),
    .stop_mode   (stop),
    .ffclk_out   (ffclk_out)
  );

  // reference generators, phases in whole cycles
  initial begin : g_int
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c++;
      if (int_ref ? (c >= int_hi) : (c >= int_lo)) begin int_ref = ~int_ref; c = 0; end
    end
  end

  initial begin : g_ext
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c++;
      if (ext_ref ? (c >= ext_hi) : (c >= ext_lo)) begin ext_ref = ~ext_ref; c = 0; end
    end
  end

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // scoreboard: kind 0 = periodic (a = period, b = high time), kind 1 = held high (a = length)
  typedef struct {
    int    kind;
    int    delay;
    int    a;
    int    b;
    string req;
  } sb_item_t;

  sb_item_t sb_q[$];
  bit mon_busy = 0;

  task automatic drain();
    @(negedge clk);
    wait (sb_q.size() == 0 && !mon_busy);
  endtask

  task automatic push_periodic(input int period, input int high, input string req);
    sb_item_t it;
    it.kind = 0; it.delay = 3 * period + 40; it.a = period; it.b = high; it.req = req;
    sb_q.push_back(it);
    drain();
  endtask

  task automatic push_held(input int delay, input int len, input string req);
    sb_item_t it;
    it.kind = 1; it.delay = delay; it.a = len; it.b = 0; it.req = req;
    sb_q.push_back(it);
    drain();
  endtask

  task automatic measure(input sb_item_t it);
    int lim, n, h, l, ones;
    repeat (it.delay) @(negedge clk);
    if (it.kind == 1) begin
      ones = 0;
      for (int i = 0; i < it.a; i++) begin
        @(negedge clk);
        if (ffclk_out === 1'b1) ones++;
      end
      check(ones == it.a, it.req, ones, it.a);
    end else begin
      lim = 4 * it.a + 200;
      n = 0;
      while (ffclk_out !== 1'b0 && n < lim) begin @(negedge clk); n++; end
      while (ffclk_out !== 1'b1 && n < lim) begin @(negedge clk); n++; end
      h = 0;
      while (ffclk_out === 1'b1 && h < lim) begin @(negedge clk); h++; end
      l = 0;
      while (ffclk_out === 1'b0 && l < lim) begin @(negedge clk); l++; end
      check(h + l == it.a, it.req, h + l, it.a);
      check(h == it.b, it.req, h, it.b);
    end
  endtask

  initial begin : g_mon
    sb_item_t it;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      mon_busy = 1;
      measure(it);
      mon_busy = 0;
    end
  end

  task automatic drive_cfg(input logic s, input logic r, input int d);
    @(negedge clk);
    sel_ext = s; rng_hi = r; div = DIV_SEL_W'(d);
  endtask

  initial begin : g_wd
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements): actual %0d expected %0d", 200000, 0);
    finish_sim();
  end

  initial begin : g_main
    int ones;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(ffclk_out === 1'b1, "R1", int'(ffclk_out), 1);   // R1 during reset
    rst_n = 1'b1;
    ones = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ffclk_out === 1'b1) ones++;
    end
    check(ones == 6, "R1", ones, 6);                        // R1 before qualification

    // R2/R3: internal source, period 10
    push_periodic(10, 5, "R2");
    drive_cfg(0, 0, 3); push_periodic(80, 40, "R3");
    drive_cfg(0, 0, 7); push_periodic(1280, 640, "R3");

    // R2: external source, period 14, ratio 2
    drive_cfg(1, 0, 1); push_periodic(28, 14, "R2");
    // R4: range extension on external source, ratio 2^(1+2)
    drive_cfg(1, 1, 1); push_periodic(112, 56, "R4");
    // R4: range bit ignored for the internal source
    drive_cfg(0, 1, 1); push_periodic(20, 10, "R4");

    // R5: period 7 is held high, period 8 toggles
    drive_cfg(0, 0, 0);
    int_hi = 4; int_lo = 3;
    push_held(60, 200, "R5");
    int_hi = 4; int_lo = 4;
    push_periodic(8, 4, "R5");
    // R5: fast source (6) made valid by division by two
    int_hi = 3; int_lo = 3;
    drive_cfg(0, 0, 1); push_periodic(12, 6, "R5");

    // R6: speed-up during operation drops validity
    int_hi = 5; int_lo = 5;
    drive_cfg(0, 0, 0); push_periodic(10, 5, "R6");
    int_hi = 3; int_lo = 3;
    push_held(40, 200, "R6");

    // R7: configuration change holds high, then new period
    int_hi = 5; int_lo = 5;
    push_periodic(10, 5, "R7");
    drive_cfg(0, 0, 4);
    push_held(8, 150, "R7");
    push_periodic(160, 80, "R7");

    // R8: stop mode
    @(negedge clk) stop = 1'b1;
    push_held(4, 300, "R8");
    @(negedge clk) stop = 1'b0;
    push_periodic(160, 80, "R8");

    // R9: bypassed low-power internal mode
    @(negedge clk) blpi = 1'b1;
    push_held(4, 300, "R9");
    @(negedge clk) blpi = 1'b0;
    push_periodic(160, 80, "R9");

    // R10: output edges track the synchronized divided clock at a new ratio
    drive_cfg(0, 0, 2); push_periodic(40, 20, "R10");

    finish_sim();
  end
endmodule